// File: doc/BRIEF.md
# Guarded Glitch-Free System Clock Selector

This block produces the system clock from one of two candidates: a slow low-speed oscillator, or a high-speed clock that is itself taken from either an on-chip oscillator or an external high-speed oscillator. Two select bits set the choice, one for the high-speed source and one for the system source. Both are written over a simple strobe-and-value interface in a control clock domain. A write is accepted only when the sources it would switch between are both reported running. The high-speed select also needs the peripheral clock enable field to be fully on. A rejected write leaves the stored bit as it was and gives no indication.

Each changeover goes through a two-stage synchronizer in each source domain. The outgoing clock is gated off on its own falling edge before the incoming clock is gated on, also on its own falling edge, so the output never carries a pulse shorter than a half-period of the sources. Separate status bits show the select that is really in effect. Those bits move only once the changeover has finished. The block also reports which oscillators are feeding the system clock and forces their enables on, whatever enables are requested from outside.

Top module: `sysclk_select`

## Requirements
- R1: After reset both stored select bits and both in-effect status bits read 0, `keep_on` reads 3'b001 and `hs_clk` follows `irc_clk`.
- R2: High-speed select encoding: 0 takes the internal oscillator `irc_clk`, 1 takes the external oscillator `xhf_clk`. Once the in-effect status agrees with the stored bit, `hs_clk` toggles at the rate of the chosen source.
- R3: A high-speed select write is stored on the next control clock edge only if `osc_run[0]` (internal) and `osc_run[1]` (external) are both 1 and `pclk_en` equals 2'b11. Otherwise `hs_sel` keeps its value.
- R4: A system select write is stored only if `osc_run[2]` (low-speed) is 1 and the oscillator named by the current `hs_sel` is running. Otherwise `sys_sel` keeps its value.
- R5: System select encoding: 0 takes `hs_clk`, 1 takes the low-speed oscillator `lsc_clk`. Once the status settles, `sys_clk` toggles at the rate of the chosen source.
- R6: `keep_on` bits are [0] internal, [1] external high-speed, [2] low-speed. A bit is set when that oscillator feeds the system clock by either the stored or the in-effect select. `osc_en` is `osc_en_req | keep_on`.
- R7: The two gate enables of each multiplexer are never on together. No pulse on `sys_clk` or `hs_clk` is shorter than the shortest source half-period.
- R8: `hs_sel_eff` and `sys_sel_eff` keep their old value in the cycle after an accepted write. They reach the new stored value only after the changeover completes, within a bounded number of control cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock for the select registers |
| rst | input | 1 | Synchronous active-high reset |
| irc_clk | input | 1 | Internal oscillator clock |
| xhf_clk | input | 1 | External high-speed oscillator clock |
| lsc_clk | input | 1 | Low-speed oscillator clock |
| osc_run | input | 3 | Running indications: [0] internal, [1] external, [2] low-speed |
| pclk_en | input | 2 | Peripheral clock enable field |
| wr_hs | input | 1 | Write strobe for the high-speed select |
| wr_hs_val | input | 1 | Value written to the high-speed select |
| wr_sys | input | 1 | Write strobe for the system select |
| wr_sys_val | input | 1 | Value written to the system select |
| osc_en_req | input | 3 | Requested oscillator enables |
| hs_sel | output | 1 | Stored high-speed select |
| sys_sel | output | 1 | Stored system select |
| hs_sel_eff | output | 1 | High-speed select in effect |
| sys_sel_eff | output | 1 | System select in effect |
| keep_on | output | 3 | Oscillators that must stay enabled |
| osc_en | output | 3 | Resulting oscillator enables |
| hs_clk | output | 1 | Selected high-speed clock |
| sys_clk | output | 1 | Selected system clock |

## Verification
The assertions assume that every source clock keeps toggling while it is selected or being switched. They also assume that reset stays high long enough to reach several edges of the slowest source, because the gate flops reset synchronously in their own domains. The stimulus keeps all three oscillators free-running for the whole run, even while `osc_run` reports one as stopped, and holds reset for many low-speed periods. It also waits for the in-effect status to settle before it issues the next write, so no changeover is ever reversed halfway through.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int OSC_N = 3;
    localparam int SYNC_DEPTH = 2;
    localparam logic [1:0] PCLK_ALL_ON = 2'b11;

    typedef enum logic {
        HS_FROM_INT = 1'b0,
        HS_FROM_EXT = 1'b1
    } hs_src_e;

    typedef enum logic {
        SYS_FROM_HS = 1'b0,
        SYS_FROM_LS = 1'b1
    } sys_src_e;

    typedef struct packed {
        logic lsc;
        logic xhf;
        logic irc;
    } osc_vec_t;

    function automatic logic hs_write_ok(osc_vec_t run, logic [1:0] pclk);
        return run.irc && run.xhf && (pclk == PCLK_ALL_ON);
    endfunction

    function automatic logic sys_write_ok(osc_vec_t run, hs_src_e hs_now);
        logic hs_alive;
        hs_alive = (hs_now == HS_FROM_EXT) ? run.xhf : run.irc;
        return run.lsc && hs_alive;
    endfunction

    function automatic osc_vec_t keep_mask(hs_src_e hs_reg, logic hs_eff,
                                           sys_src_e sys_reg, logic sys_eff);
        osc_vec_t m;
        logic uses_hs;
        uses_hs = (sys_reg == SYS_FROM_HS) || !sys_eff;
        m.lsc = (sys_reg == SYS_FROM_LS) || sys_eff;
        m.irc = uses_hs && ((hs_reg == HS_FROM_INT) || !hs_eff);
        m.xhf = uses_hs && ((hs_reg == HS_FROM_EXT) || hs_eff);
        return m;
    endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_gf_mux.sv
module clksel_gf_mux #(
    parameter int STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel,
    output logic clk_o,
    output logic gate_a,
    output logic gate_b
);
    logic want_a, want_b;
    logic sync_a, sync_b;

    // A side may only be requested once B has closed, and vice versa.
    assign want_a = !sel && !gate_b;
    assign want_b =  sel && !gate_a;

    clksel_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_a (
        .clk(clk_a), .rst(rst), .d(want_a), .q(sync_a)
    );

    clksel_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_b (
        .clk(clk_b), .rst(rst), .d(want_b), .q(sync_b)
    );

    // Gates move on the falling edge, while their own clock is low.
    always_ff @(negedge clk_a) begin
        if (rst) gate_a <= 1'b1;
        else     gate_a <= sync_a;
    end

    always_ff @(negedge clk_b) begin
        if (rst) gate_b <= 1'b0;
        else     gate_b <= sync_b;
    end

    assign clk_o = (clk_a && gate_a) || (clk_b && gate_b);

    p_gates_excl_a_r7: assert property (@(posedge clk_a) disable iff (rst)
        !(gate_a && gate_b));
    p_gates_excl_b_r7: assert property (@(posedge clk_b) disable iff (rst)
        !(gate_a && gate_b));
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       ctl_clk,
    input  logic       rst,
    input  osc_vec_t   run,
    input  logic [1:0] pclk_en,
    input  logic       wr_hs,
    input  logic       wr_hs_val,
    input  logic       wr_sys,
    input  logic       wr_sys_val,
    input  logic [3:0] gate_raw,
    output hs_src_e    hs_q,
    output sys_src_e   sys_q,
    output logic       hs_eff,
    output logic       sys_eff,
    output osc_vec_t   keep
);
    localparam int GATES = 4;

    logic [GATES-1:0] gate_s;
    logic hs_ok, sys_ok;

    // gate_raw = {sys_b, sys_a, hs_b, hs_a}; A sides reset on, B sides off.
    for (genvar g = 0; g < GATES; g++) begin : g_gate_sync
        clksel_sync #(.STAGES(STAGES), .RST_VAL((g % 2) == 0)) u_s (
            .clk(ctl_clk), .rst(rst), .d(gate_raw[g]), .q(gate_s[g])
        );
    end

    assign hs_ok  = hs_write_ok(run, pclk_en);
    assign sys_ok = sys_write_ok(run, hs_q);

    always_ff @(posedge ctl_clk) begin
        if (rst) begin
            hs_q  <= HS_FROM_INT;
            sys_q <= SYS_FROM_HS;
        end else begin
            if (wr_hs && hs_ok)   hs_q  <= hs_src_e'(wr_hs_val);
            if (wr_sys && sys_ok) sys_q <= sys_src_e'(wr_sys_val);
        end
    end

    // Status moves only when one gate is firmly on.
    always_ff @(posedge ctl_clk) begin
        if (rst) begin
            hs_eff  <= 1'b0;
            sys_eff <= 1'b0;
        end else begin
            if (gate_s[1])      hs_eff <= 1'b1;
            else if (gate_s[0]) hs_eff <= 1'b0;
            if (gate_s[3])      sys_eff <= 1'b1;
            else if (gate_s[2]) sys_eff <= 1'b0;
        end
    end

    assign keep = keep_mask(hs_q, hs_eff, sys_q, sys_eff);

    p_hs_reject_r3: assert property (@(posedge ctl_clk) disable iff (rst)
        (wr_hs && !(run.irc && run.xhf && pclk_en == 2'b11)) |=> $stable(hs_q));
    p_hs_accept_r3: assert property (@(posedge ctl_clk) disable iff (rst)
        (wr_hs && run.irc && run.xhf && pclk_en == 2'b11) |=> (hs_q == $past(wr_hs_val)));
    p_sys_reject_r4: assert property (@(posedge ctl_clk) disable iff (rst)
        (wr_sys && !run.lsc) |=> $stable(sys_q));
    p_sys_accept_r4: assert property (@(posedge ctl_clk) disable iff (rst)
        (wr_sys && run.lsc && run.irc && run.xhf) |=> (sys_q == $past(wr_sys_val)));
endmodule

// File: rtl/sysclk_select.sv
module sysclk_select
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             ctl_clk,
    input  logic             rst,
    input  logic             irc_clk,
    input  logic             xhf_clk,
    input  logic             lsc_clk,
    input  logic [OSC_N-1:0] osc_run,
    input  logic [1:0]       pclk_en,
    input  logic             wr_hs,
    input  logic             wr_hs_val,
    input  logic             wr_sys,
    input  logic             wr_sys_val,
    input  logic [OSC_N-1:0] osc_en_req,
    output logic             hs_sel,
    output logic             sys_sel,
    output logic             hs_sel_eff,
    output logic             sys_sel_eff,
    output logic [OSC_N-1:0] keep_on,
    output logic             [OSC_N-1:0] osc_en,
    output logic             hs_clk,
    output logic             sys_clk
);
    hs_src_e  hs_q;
    sys_src_e sys_q;
    osc_vec_t keep;
    logic hs_ga, hs_gb, sys_ga, sys_gb;

    clksel_regs #(.STAGES(SYNC_STAGES)) u_regs (
        .ctl_clk   (ctl_clk),
        .rst       (rst),
        .run       (osc_vec_t'(osc_run)),
        .pclk_en   (pclk_en),
        .wr_hs     (wr_hs),
        .wr_hs_val (wr_hs_val),
        .wr_sys    (wr_sys),
        .wr_sys_val(wr_sys_val),
        .gate_raw  ({sys_gb, sys_ga, hs_gb, hs_ga}),
        .hs_q      (hs_q),
        .sys_q     (sys_q),
        .hs_eff    (hs_sel_eff),
        .sys_eff   (sys_sel_eff),
        .keep      (keep)
    );

    clksel_gf_mux #(.STAGES(SYNC_STAGES)) u_hs_mux (
        .clk_a (irc_clk),
        .clk_b (xhf_clk),
        .rst   (rst),
        .sel   (hs_q == HS_FROM_EXT),
        .clk_o (hs_clk),
        .gate_a(hs_ga),
        .gate_b(hs_gb)
    );

    clksel_gf_mux #(.STAGES(SYNC_STAGES)) u_sys_mux (
        .clk_a (hs_clk),
        .clk_b (lsc_clk),
        .rst   (rst),
        .sel   (sys_q == SYS_FROM_LS),
        .clk_o (sys_clk),
        .gate_a(sys_ga),
        .gate_b(sys_gb)
    );

    assign hs_sel  = (hs_q == HS_FROM_EXT);
    assign sys_sel = (sys_q == SYS_FROM_LS);
    assign keep_on = keep;
    assign osc_en  = osc_en_req | keep;

    p_ls_kept_r6: assert property (@(posedge ctl_clk) disable iff (rst)
        sys_sel_eff |-> osc_en[2]);
    p_int_kept_r6: assert property (@(posedge ctl_clk) disable iff (rst)
        (!sys_sel_eff && !hs_sel_eff) |-> osc_en[0]);
    p_ext_kept_r6: assert property (@(posedge ctl_clk) disable iff (rst)
        (!sys_sel_eff && hs_sel_eff) |-> osc_en[1]);
endmodule

// File: tb/sysclk_select_test.sv
module sysclk_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam longint MIN_HALF = 3;

    // {op(0 hs,1 sys), value, run{lsc,xhf,irc}, pclk[1:0], exp_hs, exp_sys}
    localparam logic [8:0] VEC [0:NVEC-1] = '{
        9'b0_1_111_11_1_0,
        9'b0_0_101_11_1_0,
        9'b0_0_111_10_1_0,
        9'b1_1_011_11_1_0,
        9'b1_1_101_11_1_0,
        9'b1_1_110_11_1_1,
        9'b0_0_111_11_0_1,
        9'b1_0_110_11_0_1,
        9'b1_0_111_11_0_0,
        9'b0_1_111_01_0_0,
        9'b0_1_110_11_0_0,
        9'b0_1_111_11_1_0
    };

    logic ctl_clk = 0, rst = 1;
    logic irc_clk = 0, xhf_clk = 0, lsc_clk = 0;
    logic [2:0] osc_run = 3'b111;
    logic [1:0] pclk_en = 2'b11;
    logic wr_hs = 0, wr_hs_val = 0, wr_sys = 0, wr_sys_val = 0;
    logic [2:0] osc_en_req = 3'b000;
    logic hs_sel, sys_sel, hs_sel_eff, sys_sel_eff;
    logic [2:0] keep_on, osc_en;
    logic hs_clk, sys_clk;

    int total = 0, bad = 0;
    int n_irc = 0, n_xhf = 0, n_lsc = 0, n_hs = 0, n_sys = 0;
    int glitches = 0;
    logic meas = 0;
    longint last_sys = 0, last_hs = 0;

    sysclk_select uut (
        .ctl_clk(ctl_clk), .rst(rst), .irc_clk(irc_clk), .xhf_clk(xhf_clk),
        .lsc_clk(lsc_clk), .osc_run(osc_run), .pclk_en(pclk_en),
        .wr_hs(wr_hs), .wr_hs_val(wr_hs_val), .wr_sys(wr_sys),
        .wr_sys_val(wr_sys_val), .osc_en_req(osc_en_req), .hs_sel(hs_sel),
        .sys_sel(sys_sel), .hs_sel_eff(hs_sel_eff), .sys_sel_eff(sys_sel_eff),
        .keep_on(keep_on), .osc_en(osc_en), .hs_clk(hs_clk), .sys_clk(sys_clk)
    );

    initial forever #(CLK_PERIOD/2) ctl_clk = ~ctl_clk;
    initial forever #7  irc_clk = ~irc_clk;
    initial forever #3  xhf_clk = ~xhf_clk;
    initial forever #23 lsc_clk = ~lsc_clk;

    always @(posedge irc_clk) n_irc++;
    always @(posedge xhf_clk) n_xhf++;
    always @(posedge lsc_clk) n_lsc++;
    always @(posedge hs_clk)  n_hs++;
    always @(posedge sys_clk) n_sys++;

    always @(sys_clk) begin
        if (meas && ($time - last_sys) < MIN_HALF) glitches++;
        last_sys = $time;
    end
    always @(hs_clk) begin
        if (meas && ($time - last_hs) < MIN_HALF) glitches++;
        last_hs = $time;
    end

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_rate(input string req, input int act, input int exp);
        int d;
        d = act - exp;
        total++;
        if (d > 1 || d < -1) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_clocks(input logic e_hs, input logic e_sys);
        int i0, x0, l0, h0, s0, eh, es;
        i0 = n_irc; x0 = n_xhf; l0 = n_lsc; h0 = n_hs; s0 = n_sys;
        repeat (40) @(negedge ctl_clk);
        eh = e_hs ? (n_xhf - x0) : (n_irc - i0);
        es = e_sys ? (n_lsc - l0) : eh;
        chk_rate("R2 hs_clk rate", n_hs - h0, eh);
        chk_rate("R5 sys_clk rate", n_sys - s0, es);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic cur_hs, cur_sys;
        repeat (30) @(negedge ctl_clk);
        rst = 0;
        repeat (2) @(negedge ctl_clk);
        meas = 1;

        // R1 reset state
        chk("R1 selects", {1'b0, hs_sel, sys_sel}, 3'b000);
        chk("R1 status", {1'b0, hs_sel_eff, sys_sel_eff}, 3'b000);
        chk("R1 keep_on", keep_on, 3'b001);
        chk_clocks(1'b0, 1'b0);

        cur_hs = 0; cur_sys = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic op, val, eh, es;
            int waited;
            {op, val} = VEC[i][8:7];
            eh = VEC[i][1];
            es = VEC[i][0];
            @(negedge ctl_clk);
            osc_run = VEC[i][6:4];
            pclk_en = VEC[i][3:2];
            if (op) begin wr_sys = 1; wr_sys_val = val; end
            else    begin wr_hs  = 1; wr_hs_val  = val; end
            @(negedge ctl_clk);
            wr_hs = 0; wr_sys = 0;
            if (op) chk("R4 sys_sel write", {2'b0, sys_sel}, {2'b0, es});
            else    chk("R3 hs_sel write", {2'b0, hs_sel}, {2'b0, eh});
            chk("R8 status held after write", {1'b0, hs_sel_eff, sys_sel_eff},
                {1'b0, cur_hs, cur_sys});
            waited = 0;
            while ((hs_sel_eff !== eh || sys_sel_eff !== es) && waited < 300) begin
                @(negedge ctl_clk);
                waited++;
            end
            chk("R8 status settles", {1'b0, hs_sel_eff, sys_sel_eff}, {1'b0, eh, es});
            chk("R6 keep_on", keep_on, es ? 3'b100 : (eh ? 3'b010 : 3'b001));
            chk_clocks(eh, es);
            cur_hs = eh; cur_sys = es;
            osc_run = 3'b111;
            pclk_en = 2'b11;
        end

        // R6 enable forcing: now on external high-speed, system from hs
        osc_en_req = 3'b000; @(negedge ctl_clk);
        chk("R6 osc_en forced", osc_en, 3'b010);
        osc_en_req = 3'b101; @(negedge ctl_clk);
        chk("R6 osc_en merged", osc_en, 3'b111);
        osc_en_req = 3'b001; @(negedge ctl_clk);
        chk("R6 osc_en partial", osc_en, 3'b011);

        // move system onto low-speed, then requests may not drop it
        @(negedge ctl_clk); wr_sys = 1; wr_sys_val = 1;
        @(negedge ctl_clk); wr_sys = 0;
        repeat (150) @(negedge ctl_clk);
        osc_en_req = 3'b011; @(negedge ctl_clk);
        chk("R6 low-speed kept", osc_en, 3'b111);
        chk("R5 status on low-speed", {2'b0, sys_sel_eff}, 3'b001);
        chk_clocks(1'b1, 1'b1);

        // R7 no short pulses across all changeovers
        chk_rate("R7 short pulses", glitches, 0);

        // R1 reset mid-run returns everything to defaults
        meas = 0;
        rst = 1;
        repeat (30) @(negedge ctl_clk);
        rst = 0;
        osc_en_req = 3'b000;
        repeat (2) @(negedge ctl_clk);
        chk("R1 re-reset selects", {1'b0, hs_sel, sys_sel}, 3'b000);
        chk("R1 re-reset status", {1'b0, hs_sel_eff, sys_sel_eff}, 3'b000);
        chk("R1 re-reset keep_on", keep_on, 3'b001);
        chk_clocks(1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule